// File: doc/BRIEF.md
# Bus-attached shifting temporary register

This block is a byte-wide holding register that sits on a data bus. Each clock it either keeps its contents, takes a new byte from the bus in parallel, or moves its contents by one bit position. There are four shift modes: left and right, each in a logical and an arithmetic form. The arithmetic right shift keeps the sign bit. The arithmetic left shift records a signed overflow in a sticky flag.

The stored value reaches the bus through a gate with an active-low enable. While the gate is closed the output carries zero and a drive-enable output is low, so that a bus multiplexer or pad can release the line. A synchronous active-low clear empties the register and the flag. The asynchronous reset input is released in step with the clock.

Top module: `bus_shift_reg`

## Requirements
- R1: While reset is applied, and until it has been released in step with the clock, the contents read as 0x00 and `ovf` is 0.
- R2: With `clr_n` high, mode code 1 loads `bus_in` into the contents at the next rising edge.
- R3: Mode codes 0, 6 and 7 leave the contents and `ovf` unchanged.
- R4: Mode code 2 is a logical left shift: bits move one place toward the MSB and bit 0 becomes 0.
- R5: Mode code 3 is a logical right shift: bits move one place toward the LSB and bit 7 becomes 0.
- R6: Mode code 5 is an arithmetic right shift: bits move toward the LSB and bit 7 keeps its old value.
- R7: Mode code 4 is an arithmetic left shift: bits move toward the MSB and bit 0 becomes 0.
- R8: An arithmetic left shift whose old bit 7 differs from old bit 6 sets `ovf`. Once set, `ovf` stays at 1 through every mode until a clear or a reset.
- R9: When `oe_n` is low, `bus_out` shows the contents and `bus_en` is 1. When `oe_n` is high, `bus_out` is 0x00 and `bus_en` is 0.
- R10: When `clr_n` is low at a rising edge, the contents and `ovf` become 0 whatever the mode code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr_n | input | 1 | Synchronous active-low clear of the contents and the flag |
| mode | input | 3 | Operation code: 0 hold, 1 load, 2 logical left, 3 logical right, 4 arithmetic left, 5 arithmetic right, 6 and 7 hold |
| bus_in | input | 8 | Byte taken from the bus on a load |
| oe_n | input | 1 | Active-low output enable |
| bus_out | output | 8 | Gated contents (zero while disabled) |
| bus_en | output | 1 | High while the block drives the bus |
| ovf | output | 1 | Sticky arithmetic-left overflow |

## Verification
The hardest case to reach is sticky overflow. The flag must be seen to rise on exactly the arithmetic left shift where bits 7 and 6 differ. It must then stay set through later loads, shifts and holds, including holds with spare codes, and be cleared only by `clr_n`. Directed sequences load chosen bytes such as 0x40 and 0xC1 before shifting, which produces both the setting case and the non-setting case. A long random run then mixes all eight codes, occasional clears and random output enables against a behavioural model. Because the run reaches the flag in many different states, stickiness is tested far from the moment the flag was set.

// File: rtl/bus_shift_reg_pkg.sv
package bus_shift_reg_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_LSL   = 3'd2,
    OP_LSR   = 3'd3,
    OP_ASL   = 3'd4,
    OP_ASR   = 3'd5,
    OP_SPARE6 = 3'd6,
    OP_SPARE7 = 3'd7
  } op_e;
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsr_next.sv
module bsr_next
  import bus_shift_reg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]      cur_q,
  input  logic              cur_ovf,
  input  logic              clr_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      nxt_q,
  output logic              nxt_ovf,
  output logic              upd_en
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    nxt_q   = cur_q;
    nxt_ovf = cur_ovf;
    upd_en  = 1'b0;
    if (!clr_n) begin
      nxt_q   = '0;
      nxt_ovf = 1'b0;
      upd_en  = 1'b1;
    end else begin
      unique case (op_e'(mode))
        OP_LOAD: begin
          nxt_q  = din;
          upd_en = 1'b1;
        end
        OP_LSL: begin
          nxt_q  = {cur_q[MSB-1:0], 1'b0};
          upd_en = 1'b1;
        end
        OP_LSR: begin
          nxt_q  = {1'b0, cur_q[MSB:1]};
          upd_en = 1'b1;
        end
        OP_ASL: begin
          nxt_q   = {cur_q[MSB-1:0], 1'b0};
          nxt_ovf = cur_ovf | (cur_q[MSB] ^ cur_q[MSB-1]);
          upd_en  = 1'b1;
        end
        OP_ASR: begin
          nxt_q  = {cur_q[MSB], cur_q[MSB:1]};
          upd_en = 1'b1;
        end
        default: begin
          upd_en = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bsr_outgate.sv
module bsr_outgate #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] q,
  input  logic         oe_n,
  output logic [W-1:0] bus_out,
  output logic         bus_en
);
  assign bus_en  = ~oe_n;
  assign bus_out = q & {W{bus_en}};
endmodule

// File: rtl/bus_shift_reg.sv
module bus_shift_reg
  import bus_shift_reg_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      bus_in,
  input  logic              oe_n,
  output logic [W-1:0]      bus_out,
  output logic              bus_en,
  output logic              ovf
);
  logic         rst_sync_n;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         ovf_r;
  logic         ovf_nxt;
  logic         upd_en;

  bsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsr_next #(.W(W)) u_next (
    .cur_q   (q_r),
    .cur_ovf (ovf_r),
    .clr_n   (clr_n),
    .mode    (mode),
    .din     (bus_in),
    .nxt_q   (q_nxt),
    .nxt_ovf (ovf_nxt),
    .upd_en  (upd_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_r   <= '0;
      ovf_r <= 1'b0;
    end else if (upd_en) begin
      q_r   <= q_nxt;
      ovf_r <= ovf_nxt;
    end
  end

  bsr_outgate #(.W(W)) u_gate (
    .q       (q_r),
    .oe_n    (oe_n),
    .bus_out (bus_out),
    .bus_en  (bus_en)
  );

  assign ovf = ovf_r;
endmodule

// File: rtl/bus_shift_reg_chk.sv
module bus_shift_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         clr_n,
  input logic [2:0]   mode,
  input logic [W-1:0] bus_in,
  input logic         oe_n,
  input logic [W-1:0] bus_out,
  input logic         bus_en,
  input logic         ovf,
  input logic [W-1:0] q_r
);
  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    oe_n |-> (bus_out == '0) && !bus_en);
  // R9
  gate_on_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !oe_n |-> (bus_out == q_r) && bus_en);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_n |=> (q_r == '0) && !ovf);
  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf && clr_n) |=> ovf);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && mode == 3'd1) |=> (q_r == $past(bus_in)));
  // R6
  asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && mode == 3'd5) |=> (q_r[W-1] == $past(q_r[W-1])) && (q_r[W-2:0] == $past(q_r[W-1:1])));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && (mode == 3'd0 || mode == 3'd6 || mode == 3'd7)) |=> $stable(q_r) && $stable(ovf));
endmodule

bind bus_shift_reg bus_shift_reg_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .clr_n      (clr_n),
  .mode       (mode),
  .bus_in     (bus_in),
  .oe_n       (oe_n),
  .bus_out    (bus_out),
  .bus_en     (bus_en),
  .ovf        (ovf),
  .q_r        (q_r)
);

// File: tb/test_bus_shift_reg.sv
module test_bus_shift_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_n;
  logic [2:0] mode;
  logic [7:0] bus_in;
  logic       oe_n;
  logic [7:0] bus_out;
  logic       bus_en;
  logic       ovf;

  int checks = 0;
  int errors = 0;
  int mq = 0;
  int movf = 0;

  always #4 clk = ~clk;

  bus_shift_reg i_bus_shift_reg (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .mode(mode),
    .bus_in(bus_in), .oe_n(oe_n), .bus_out(bus_out),
    .bus_en(bus_en), .ovf(ovf)
  );

  function automatic string tag_of(input logic c, input logic [2:0] m);
    if (!c) return "R10";
    case (m)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic c, input logic [2:0] m, input logic [7:0] d);
    int b7, b6;
    b7 = (mq >> 7) & 1;
    b6 = (mq >> 6) & 1;
    if (!c) begin
      mq = 0; movf = 0;
    end else begin
      case (m)
        3'd1: mq = d;
        3'd2: mq = (mq * 2) % 256;
        3'd3: mq = mq / 2;
        3'd4: begin
          mq = (mq * 2) % 256;
          if (b7 != b6) movf = 1;
        end
        3'd5: mq = mq / 2 + b7 * 128;
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic c, input logic [2:0] m, input logic [7:0] d, input logic oe);
    string t;
    clr_n = c; mode = m; bus_in = d; oe_n = oe;
    t = tag_of(c, m);
    @(posedge clk);
    model(c, m, d);
    #2;
    if (!oe) begin
      check(t, int'(bus_out), mq);
      check("R9", int'(bus_en), 1);
    end else begin
      check("R9", int'(bus_out), 0);
      check("R9", int'(bus_en), 0);
    end
    if (m == 3'd4 || !c) check("R8", int'(ovf), movf);
    else                 check({t, "/R8"}, int'(ovf), movf);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; mode = 3'd1; bus_in = 8'hA5; oe_n = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    check("R1", int'(bus_out), 0);
    check("R1", int'(ovf), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    mode = 3'd0;
    check("R1", int'(bus_out), 0);
    repeat (3) @(posedge clk);
    #2;
    check("R1", int'(bus_out), 0);
    check("R1", int'(ovf), 0);

    step(1, 3'd1, 8'h81, 0);
    step(1, 3'd2, 8'h00, 0);   // R4: 0x81 -> 0x02
    step(1, 3'd1, 8'h81, 0);
    step(1, 3'd3, 8'h00, 0);   // R5: 0x81 -> 0x40
    step(1, 3'd1, 8'h81, 0);
    step(1, 3'd5, 8'h00, 0);   // R6: 0x81 -> 0xC0
    step(1, 3'd5, 8'h00, 0);   // R6: 0xC0 -> 0xE0
    step(1, 3'd1, 8'hC1, 0);
    step(1, 3'd4, 8'h00, 0);   // R7: 0xC1 -> 0x82, no overflow
    step(1, 3'd6, 8'h55, 0);   // R3
    step(1, 3'd7, 8'h55, 1);   // R3, R9 gate closed
    step(1, 3'd0, 8'h55, 0);   // R3 still 0x82
    step(1, 3'd1, 8'h40, 0);
    step(1, 3'd4, 8'h00, 0);   // R8: 0x40 -> 0x80, overflow set
    step(1, 3'd1, 8'h01, 0);   // R8 sticky through load
    step(1, 3'd3, 8'h00, 0);
    step(1, 3'd4, 8'h00, 0);   // R8 sticky through quiet shift
    step(0, 3'd1, 8'hFF, 0);   // R10 clear beats load
    step(1, 3'd0, 8'h00, 0);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 16) != 0, 3'($urandom), 8'($urandom), ($urandom % 4) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule